// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a downstream or root port that supports native hot-plug. Software programs enables, indicators, slot power and the electromechanical interlock through a 16-bit configuration write port with byte enables. It reads either register back through a combinational read port. A device-side interface reports a hot-add, requests a removal and signals attention-button presses. The block latches the resulting events and runs the removal sequence when it is due.

The block also produces the hot-plug interrupt. A pending condition is formed from the hot-plug interrupt enable, the latched events and their per-event enables. In INTx mode the interrupt line follows that condition. In message mode a single one-cycle pulse is raised when the condition becomes true, and a separate message unit formats the actual message.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Register layout: control (address 0) holds abp-enable bit 0, pdc-enable bit 1, cc-enable bit 2, hot-plug interrupt enable bit 3, attention indicator bits 5:4, power indicator bits 7:6, power control bit 8 (1 = off) and interlock control bit 9. Status (address 1) holds attention-button event bit 0, presence-detect-changed bit 1, command-completed bit 2, presence bit 3, interlock status bit 4 and link-active bit 5. Byte enable 0 covers bits 7:0 and byte enable 1 covers bits 15:8.
- R2: The pending condition is true when the hot-plug interrupt enable is 1 and at least one of the three events (bits 0..2 of status) is latched with its enable set. With message mode low, `intx_level` equals the pending condition.
- R3: With message mode high, `intx_level` stays 0 and `msi_pulse` is high for exactly one cycle each time the pending condition goes from false to true.
- R4: Latching an event that is already set, while the pending condition stays true, produces no further message pulse.
- R5: Writing 1 to control bit 9 toggles interlock status. Writing 0 leaves it unchanged. Bit 9 always reads back as 0.
- R6: Any control write with a nonzero byte enable latches command-completed.
- R7: A control write that moves the slot from not powered off to powered off (power control 1 and power indicator 11) while presence is 1 clears presence and link-active and sets presence-detect-changed.
- R8: A hot-add sets presence and link-active and latches both presence-detect-changed and attention-button.
- R9: A removal request is refused, with no status change, when interlock status is 1 or the power indicator is blinking. Otherwise, if the slot is powered off, presence and link-active clear, presence-detect-changed sets and attention-button clears. If the slot is not powered off, attention-button sets instead.
- R10: Reset sets the control register to 0x01F0 (both indicators off, power off, all enables 0) and the status register to 0.
- R11: Indicator codes are on = 01, blink = 10, off = 11, and they drive `pwr_ind` and `attn_ind`. `slot_pwr_en` is the inverse of power control.
- R12: Status bits 0..2 are write-1-to-clear under the byte enables. Clearing the last pending event drops `intx_level` in the following cycle.
- R13: An attention-button press from the device side latches the attention-button event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 status (read and write) |
| cfg_wdata | input | 16 | Write data |
| cfg_be | input | 2 | Byte enables |
| cfg_rdata | output | 16 | Read data of the selected register |
| msi_mode | input | 1 | 1 = message interrupts, 0 = INTx level |
| dev_add | input | 1 | Device hot-add pulse |
| dev_rm_req | input | 1 | Removal request pulse |
| dev_attn | input | 1 | Attention-button press pulse |
| intx_level | output | 1 | INTx interrupt level |
| msi_pulse | output | 1 | One-cycle message request |
| slot_pwr_en | output | 1 | Slot power enable |
| pwr_ind | output | 2 | Power indicator state |
| attn_ind | output | 2 | Attention indicator state |

## Verification
The bench repeats a control write while command-completed is already latched. A design that notified on every event set would emit a second message pulse there. It clears events with W1C writes and then checks that the INTx line drops; a design that only raised the line on changes would leave it stuck high. Removal requests are sent with the interlock engaged, with a blinking indicator, with the slot powered and with the slot powered off. Each of the four cases has a distinct status result, so a wrong priority between refusal and removal shows up as a wrong presence or attention bit. The bench also writes the interlock control bit and confirms that it reads back 0 while the status toggles, and that a write with no byte enable changes nothing.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
  localparam int DW      = 16;
  localparam int BE_W    = DW / 8;
  localparam int ILK_BIT = 9;

  localparam logic [1:0] IND_ON    = 2'b01;
  localparam logic [1:0] IND_BLINK = 2'b10;
  localparam logic [1:0] IND_OFF   = 2'b11;

  typedef struct packed {
    logic       pwr_off;
    logic [1:0] pwr_ind;
    logic [1:0] attn_ind;
    logic       hpie;
    logic       cc_en;
    logic       pdc_en;
    logic       abp_en;
  } ctrl_t;

  typedef struct packed {
    logic dll;
    logic ilk;
    logic pres;
    logic cc;
    logic pdc;
    logic abp;
  } sts_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STS_W  = $bits(sts_t);
  localparam ctrl_t CTRL_RST = ctrl_t'(9'h1F0);

  function automatic logic [DW-1:0] be_mask(input logic [BE_W-1:0] be);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [DW-1:0] merge_word(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [BE_W-1:0] be);
    logic [DW-1:0] m;
    m = be_mask(be);
    return (old_w & ~m) | (new_w & m);
  endfunction

  function automatic logic [DW-1:0] ctrl_word(input ctrl_t c);
    return {{(DW-CTRL_W){1'b0}}, c};
  endfunction

  function automatic logic [DW-1:0] sts_word(input sts_t s);
    return {{(DW-STS_W){1'b0}}, s};
  endfunction

  function automatic logic powered_off(input ctrl_t c);
    return c.pwr_off && (c.pwr_ind == IND_OFF);
  endfunction

  function automatic logic hp_pending(input ctrl_t c, input sts_t s);
    return c.hpie && ((s.abp && c.abp_en) || (s.pdc && c.pdc_en) || (s.cc && c.cc_en));
  endfunction
endpackage

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
  import hpslot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic [BE_W-1:0] be,
  output ctrl_t           ctrl_q,
  output logic            cc_evt,
  output logic            ilk_toggle,
  output logic            pwroff_evt
);
  logic [DW-1:0] merged;
  logic [DW-1:0] wmask;
  ctrl_t         ctrl_nxt;

  always_comb begin
    wmask      = be_mask(be);
    merged     = merge_word(ctrl_word(ctrl_q), wdata, be);
    ctrl_nxt   = ctrl_t'(merged[CTRL_W-1:0]);
    cc_evt     = wr_en;
    ilk_toggle = wr_en && wmask[ILK_BIT] && wdata[ILK_BIT];
    pwroff_evt = wr_en && powered_off(ctrl_nxt) && !powered_off(ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= ctrl_nxt;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q)); // R1
endmodule

// File: rtl/hpslot_status.sv
module hpslot_status
  import hpslot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic [BE_W-1:0] be,
  input  logic            cc_evt,
  input  logic            ilk_toggle,
  input  logic            pwroff_evt,
  input  ctrl_t           ctrl_q,
  input  logic            dev_add,
  input  logic            dev_rm_req,
  input  logic            dev_attn,
  output sts_t            sts_q,
  output logic            rm_refused,
  output logic            rm_seq
);
  logic [DW-1:0] clr;
  logic          rm_now;
  logic          rm_attn;
  sts_t          sts_nxt;

  always_comb begin
    clr        = wr_en ? (wdata & be_mask(be)) : '0;
    rm_refused = dev_rm_req && (sts_q.ilk || (ctrl_q.pwr_ind == IND_BLINK));
    rm_now     = dev_rm_req && !rm_refused && powered_off(ctrl_q);
    rm_attn    = dev_rm_req && !rm_refused && !powered_off(ctrl_q);
    rm_seq     = (pwroff_evt && sts_q.pres) || rm_now;

    sts_nxt     = sts_q;
    sts_nxt.abp = sts_q.abp && !clr[0];
    sts_nxt.pdc = sts_q.pdc && !clr[1];
    sts_nxt.cc  = sts_q.cc  && !clr[2];
    if (cc_evt)     sts_nxt.cc  = 1'b1;
    if (ilk_toggle) sts_nxt.ilk = !sts_q.ilk;
    if (rm_seq) begin
      sts_nxt.pres = 1'b0;
      sts_nxt.dll  = 1'b0;
      sts_nxt.pdc  = 1'b1;
    end
    if (rm_now)             sts_nxt.abp = 1'b0;
    if (rm_attn || dev_attn) sts_nxt.abp = 1'b1;
    if (dev_add) begin
      sts_nxt.pres = 1'b1;
      sts_nxt.dll  = 1'b1;
      sts_nxt.pdc  = 1'b1;
      sts_nxt.abp  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_nxt;
  end

  AST_ILK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_toggle |=> (sts_q.ilk != $past(sts_q.ilk))); // R5
  AST_CC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cc_evt |=> sts_q.cc); // R6
  AST_RM_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pwroff_evt && sts_q.pres && !dev_add) |=> (!sts_q.pres && !sts_q.dll && sts_q.pdc)); // R7
  AST_HOT_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_add |=> (sts_q.pres && sts_q.dll && sts_q.pdc && sts_q.abp)); // R8
  AST_RM_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_refused && !dev_add && !pwroff_evt) |=> $stable(sts_q.pres)); // R9
  AST_W1C_PDC: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[1] && !dev_add && !rm_seq) |=> !sts_q.pdc); // R12
  AST_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
    dev_attn |=> sts_q.abp); // R13
endmodule

// File: rtl/hpslot_irq.sv
module hpslot_irq
  import hpslot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  msi_mode,
  input  ctrl_t ctrl_q,
  input  sts_t  sts_q,
  output logic  pend,
  output logic  intx_level,
  output logic  msi_pulse
);
  logic pend_prev;

  always_comb begin
    pend       = hp_pending(ctrl_q, sts_q);
    intx_level = !msi_mode && pend;
    msi_pulse  = msi_mode && pend && !pend_prev;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_prev <= 1'b0;
    else        pend_prev <= pend;
  end

  AST_MSI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |=> !msi_pulse); // R3
  AST_MSI_NO_INTX: assert property (@(posedge clk) disable iff (!rst_n)
    msi_mode |-> !intx_level); // R3
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> !msi_pulse); // R4
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hpslot_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic [BE_W-1:0] cfg_be,
  output logic [DW-1:0]   cfg_rdata,
  input  logic            msi_mode,
  input  logic            dev_add,
  input  logic            dev_rm_req,
  input  logic            dev_attn,
  output logic            intx_level,
  output logic            msi_pulse,
  output logic            slot_pwr_en,
  output logic [1:0]      pwr_ind,
  output logic [1:0]      attn_ind
);
  ctrl_t ctrl_q;
  sts_t  sts_q;
  logic  wr_ctrl, wr_sts;
  logic  cc_evt, ilk_toggle, pwroff_evt;
  logic  rm_refused, rm_seq, pend;

  assign wr_ctrl = cfg_wr && !cfg_addr && (|cfg_be);
  assign wr_sts  = cfg_wr && cfg_addr;

  hpslot_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(cfg_wdata), .be(cfg_be),
    .ctrl_q(ctrl_q), .cc_evt(cc_evt), .ilk_toggle(ilk_toggle), .pwroff_evt(pwroff_evt)
  );

  hpslot_status u_sts (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sts), .wdata(cfg_wdata), .be(cfg_be),
    .cc_evt(cc_evt), .ilk_toggle(ilk_toggle), .pwroff_evt(pwroff_evt), .ctrl_q(ctrl_q),
    .dev_add(dev_add), .dev_rm_req(dev_rm_req), .dev_attn(dev_attn),
    .sts_q(sts_q), .rm_refused(rm_refused), .rm_seq(rm_seq)
  );

  hpslot_irq u_irq (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .ctrl_q(ctrl_q), .sts_q(sts_q),
    .pend(pend), .intx_level(intx_level), .msi_pulse(msi_pulse)
  );

  assign cfg_rdata   = cfg_addr ? sts_word(sts_q) : ctrl_word(ctrl_q);
  assign slot_pwr_en = !ctrl_q.pwr_off;
  assign pwr_ind     = ctrl_q.pwr_ind;
  assign attn_ind    = ctrl_q.attn_ind;

  AST_ILK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_addr |-> !cfg_rdata[ILK_BIT]); // R5
  AST_PWR_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_pwr_en) |-> $past(wr_ctrl)); // R11
endmodule

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] data;
    logic [1:0]  be;
    logic [15:0] ectrl;
    logic [15:0] ests;
    logic        eintx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 16'h01F0, 2'b11, 16'h01F0, 16'h0004, 1'b0},
    '{2'd1, 16'h0004, 2'b01, 16'h01F0, 16'h0000, 1'b0},
    '{2'd0, 16'h01F3, 2'b01, 16'h01F3, 16'h0004, 1'b0},
    '{2'd1, 16'h0004, 2'b01, 16'h01F3, 16'h0000, 1'b0},
    '{2'd2, 16'h0000, 2'b00, 16'h01F3, 16'h002B, 1'b0},
    '{2'd0, 16'h01FB, 2'b01, 16'h01FB, 16'h002F, 1'b1},
    '{2'd1, 16'h0003, 2'b01, 16'h01FB, 16'h002C, 1'b0},
    '{2'd0, 16'h00FB, 2'b10, 16'h00FB, 16'h002C, 1'b0},
    '{2'd0, 16'h01FB, 2'b10, 16'h01FB, 16'h0006, 1'b1},
    '{2'd1, 16'h0006, 2'b01, 16'h01FB, 16'h0000, 1'b0},
    '{2'd0, 16'h03FB, 2'b10, 16'h01FB, 16'h0014, 1'b0},
    '{2'd1, 16'h0004, 2'b00, 16'h01FB, 16'h0014, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  cfg_be = '0;
  logic [15:0] cfg_rdata;
  logic        msi_mode = 1'b0;
  logic        dev_add = 1'b0, dev_rm_req = 1'b0, dev_attn = 1'b0;
  logic        intx_level, msi_pulse, slot_pwr_en;
  logic [1:0]  pwr_ind, attn_ind;

  int checks = 0;
  int errors = 0;
  int msi_cnt = 0;
  bit done = 1'b0;

  hp_slot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .msi_mode(msi_mode), .dev_add(dev_add), .dev_rm_req(dev_rm_req), .dev_attn(dev_attn),
    .intx_level(intx_level), .msi_pulse(msi_pulse), .slot_pwr_en(slot_pwr_en),
    .pwr_ind(pwr_ind), .attn_ind(attn_ind)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (rst_n && msi_pulse) msi_cnt++;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic cfg_write(input logic a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = b;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic dev_pulse(input int which);
    @(negedge clk);
    dev_add = (which == 0); dev_rm_req = (which == 1); dev_attn = (which == 2);
    @(negedge clk);
    dev_add = 1'b0; dev_rm_req = 1'b0; dev_attn = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    logic [15:0] v;
    rd(1'b0, v); check("R10 ctrl reset", v, 16'h01F0);
    rd(1'b1, v); check("R10 sts reset", v, 16'h0000);
    check("R10 intx reset", {15'd0, intx_level}, 16'd0);
    check("R11 pwr_en at reset", {15'd0, slot_pwr_en}, 16'd0);
    check("R11 indicators off", {12'd0, pwr_ind, attn_ind}, 16'h000F);
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int c0;
    do_reset();
    check_reset_state();

    // Table walk in INTx mode: R1 R2 R5 R6 R7 R8 R12
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: cfg_write(1'b0, TBL[i].data, TBL[i].be);
        2'd1: cfg_write(1'b1, TBL[i].data, TBL[i].be);
        default: dev_pulse(0);
      endcase
      rd(1'b0, v); check($sformatf("R1/R5 ctrl step %0d", i), v, TBL[i].ectrl);
      rd(1'b1, v); check($sformatf("R6/R7/R8/R12 sts step %0d", i), v, TBL[i].ests);
      check($sformatf("R2 intx step %0d", i), {15'd0, intx_level}, {15'd0, TBL[i].eintx});
      if (i == 7) check("R11 pwr_en on", {15'd0, slot_pwr_en}, 16'd1);
    end

    // Message mode: R3 R4
    cfg_write(1'b1, 16'h0007, 2'b01);
    msi_mode = 1'b1;
    c0 = msi_cnt;
    cfg_write(1'b0, 16'h01FC, 2'b01);
    check("R3 msi pulse on rise", {15'd0, msi_pulse}, 16'd1);
    check("R3 no intx in msi mode", {15'd0, intx_level}, 16'd0);
    @(negedge clk);
    check("R3 pulse one cycle", {15'd0, msi_pulse}, 16'd0);
    cfg_write(1'b0, 16'h01FC, 2'b01);
    repeat (3) @(negedge clk);
    check("R4 no repeat pulse", msi_cnt[15:0], 16'(c0 + 1));
    cfg_write(1'b1, 16'h0004, 2'b01);
    repeat (2) @(negedge clk);
    check("R3 no pulse on fall", msi_cnt[15:0], 16'(c0 + 1));
    cfg_write(1'b0, 16'h01FC, 2'b01);
    repeat (2) @(negedge clk);
    check("R3 pulse on new rise", msi_cnt[15:0], 16'(c0 + 2));
    msi_mode = 1'b0;

    // Removal requests: R9, plus R11 R12 R13
    cfg_write(1'b1, 16'h0007, 2'b01);
    check("R12 intx drops after clear", {15'd0, intx_level}, 16'd0);
    dev_pulse(0);
    cfg_write(1'b1, 16'h0007, 2'b01);
    rd(1'b1, v); check("R8 add with interlock", v, 16'h0038);
    dev_pulse(1);
    rd(1'b1, v); check("R9 refused interlock", v, 16'h0038);
    cfg_write(1'b0, 16'h0300, 2'b10);
    rd(1'b1, v); check("R5 interlock released", v, 16'h002C);
    check("R2 intx on cc", {15'd0, intx_level}, 16'd1);
    cfg_write(1'b0, 16'h00BC, 2'b01);
    check("R11 blink code", {14'd0, pwr_ind}, 16'h0002);
    cfg_write(1'b1, 16'h0004, 2'b01);
    check("R12 intx cleared", {15'd0, intx_level}, 16'd0);
    dev_pulse(1);
    rd(1'b1, v); check("R9 refused blink", v, 16'h0028);
    cfg_write(1'b0, 16'h00FC, 2'b11);
    check("R11 power on", {15'd0, slot_pwr_en}, 16'd1);
    cfg_write(1'b1, 16'h0004, 2'b01);
    dev_pulse(1);
    rd(1'b1, v); check("R9 powered: attention", v, 16'h0029);
    cfg_write(1'b1, 16'h0007, 2'b01);
    cfg_write(1'b0, 16'h0100, 2'b10);
    rd(1'b1, v); check("R7 power-off removal", v, 16'h0006);
    cfg_write(1'b1, 16'h0007, 2'b01);
    dev_pulse(0);
    cfg_write(1'b1, 16'h0007, 2'b01);
    dev_pulse(1);
    rd(1'b1, v); check("R9 immediate removal", v, 16'h0002);
    dev_pulse(2);
    rd(1'b1, v); check("R13 attention press", v, 16'h0003);

    // Mid-run reset: R10
    do_reset();
    check_reset_state();
    finish_run();
  end
endmodule